// File: doc/BRIEF.md
# Interrupt Pending and Configuration Distributor

This block keeps the per-interrupt state of a small multi-core interrupt controller. For each interrupt it stores an enable bit, one pending bit per core, a handling-model bit and an edge/level trigger bit. For each external input line it stores the last sampled level and a core target mask. It turns line transitions, byte-wide register writes and 32-bit software-interrupt command words into updates of that state. It drives the enable and per-core pending vectors to a downstream priority arbiter. The model and trigger vectors go to the acknowledge logic.

Interrupt numbers 0 to 31 are private to each core and have no input line. External line k is interrupt 32+k. Every register access and software command carries the number of the requesting core. All updates of one cycle are merged and registered at the next rising clock edge. Line events are applied first, then the register write, then the software command.

Top module: `irq_distributor`

## Requirements
- R1: After reset, interrupts 0..15 are enabled and edge-triggered. All other enable, model and trigger bits are 0, all pending bits are 0 and `acc_err` is 0.
- R2: A low-to-high change on line k sets pending for interrupt 32+k on every core in its target mask, visible one cycle later. This happens only if the interrupt is edge-triggered or enabled.
- R3: A line that rises while its interrupt is level-triggered and disabled pends nothing. A falling line leaves pending unchanged and clears only the stored level, so a later set-enable pends nothing.
- R4: A line held high does not pend again once its pending bit has been cleared.
- R5: A set-enable write (`wr_op`=0, group `wr_index`, interrupts 8*index+b for each `wr_data[b]`=1) enables the interrupt. If the interrupt is level-triggered and its line is high, the write also pends it on the target cores.
- R6: Set-enable writes to groups covering interrupts 0..15 act as all ones. Clear-enable writes (`wr_op`=1, same layout) to those groups act as zero, so interrupts 0..15 stay enabled.
- R7: A configuration write (`wr_op`=4) covers interrupts 4*index+j. Bit 2j of the data sets the 1-of-N model and bit 2j+1 sets edge trigger. For interrupts below 32 the trigger bits are forced to 1.
- R8: A clear-pending write (`wr_op`=3, same layout as R5) clears the pending bit on every core.
- R9: A set-pending write (`wr_op`=2, same layout as R5) pends the requesting core for interrupts below 32, and the target cores for interrupts 32 and above.
- R10: A software command takes the ID from bits [9:0] and the filter from bits [25:24]. Filter 0 pends the cores listed in bits [16+NCORE-1:16], 1 pends the requester, 2 pends all cores but the requester, and 3 pends all cores.
- R11: A target write (`wr_op`=5, `wr_index` is the interrupt, `wr_data[NCORE-1:0]` is the mask) is ignored below 32. The target read port returns 0 below 29, the requester's one-hot bit for 29..31, and the stored mask for 32 and above.
- R12: An access whose first interrupt is at or beyond NIRQ, or a software ID at or beyond NIRQ, changes no state and raises `acc_err` for exactly one cycle. `wr_op` codes 6 and 7 are ignored without error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_line | input | NIRQ-32 | External interrupt lines; line k is interrupt 32+k |
| wr_valid | input | 1 | Register write strobe |
| wr_op | input | 3 | Write kind: 0 set-enable, 1 clear-enable, 2 set-pending, 3 clear-pending, 4 configuration, 5 target |
| wr_index | input | 10 | Group index, or interrupt number for target writes |
| wr_data | input | 8 | Write byte |
| req_core | input | CORE_W | Requesting core for writes, commands and target reads |
| sgi_valid | input | 1 | Software-interrupt command strobe |
| sgi_word | input | 32 | Software-interrupt command word |
| tgt_rd_id | input | 10 | Interrupt number for the target read port |
| tgt_rd_data | output | NCORE | Target mask read back |
| en_vec | output | NIRQ | Enable bit per interrupt |
| pend_vec | output | NCORE*NIRQ | Pending bits; bit c*NIRQ+i is core c, interrupt i |
| model_vec | output | NIRQ | 1-of-N model bit per interrupt |
| edge_vec | output | NIRQ | Edge-trigger bit per interrupt |
| acc_err | output | 1 | One-cycle flag for an out-of-range access |

## Verification
The stored line level cannot be seen at the ports, so the hardest case is proving that it governs pending correctly. Three situations depend on it: a level interrupt enabled while its line is high, a held line after pending was cleared, and an enable that follows a falling line. The bench reaches these by setting a target mask and a level configuration, then interleaving line transitions with set-enable and clear-pending writes. After each step it reads the pending bits. Software commands are sent with every filter value and both requesting cores, so each core mask shape is observed.

// File: rtl/dist_pkg.sv
package dist_pkg;
    localparam int ID_W = 10;

    typedef enum logic [2:0] {
        OP_SET_EN   = 3'd0,
        OP_CLR_EN   = 3'd1,
        OP_SET_PEND = 3'd2,
        OP_CLR_PEND = 3'd3,
        OP_CONFIG   = 3'd4,
        OP_TARGET   = 3'd5,
        OP_RSV6     = 3'd6,
        OP_RSV7     = 3'd7
    } dist_op_e;
endpackage

// File: rtl/dist_line_detect.sv
module dist_line_detect #(
    parameter int NLINE = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NLINE-1:0] line_in,
    output logic [NLINE-1:0] level_q,
    output logic [NLINE-1:0] rise
);
    always_ff @(posedge clk) begin
        if (!rst_n) level_q <= '0;
        else        level_q <= line_in;
    end

    assign rise = line_in & ~level_q;
endmodule

// File: rtl/dist_sgi_decode.sv
module dist_sgi_decode import dist_pkg::*; #(
    parameter int NCORE  = 2,
    parameter int CORE_W = 1
) (
    input  logic [31:0]       word,
    input  logic [CORE_W-1:0] req_core,
    output logic [ID_W-1:0]   id,
    output logic [NCORE-1:0]  mask
);
    logic [NCORE-1:0] self_bit;
    logic             unused_word;

    assign unused_word = ^word;
    assign id          = word[ID_W-1:0];

    always_comb begin
        self_bit           = '0;
        self_bit[req_core] = 1'b1;
        unique case (word[25:24])
            2'd0:    mask = word[16 +: NCORE];
            2'd1:    mask = self_bit;
            2'd2:    mask = ~self_bit;
            default: mask = '1;
        endcase
    end
endmodule

// File: rtl/dist_target_regs.sv
module dist_target_regs import dist_pkg::*; #(
    parameter int NCORE  = 2,
    parameter int NIRQ   = 64,
    parameter int CORE_W = 1
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en,
    input  logic [ID_W-1:0]             wr_id,
    input  logic [NCORE-1:0]            wr_mask,
    input  logic [ID_W-1:0]             rd_id,
    input  logic [CORE_W-1:0]           req_core,
    output logic [NCORE-1:0]            rd_mask,
    output logic [NIRQ-33:0][NCORE-1:0] tgt
);
    localparam int NLINE = NIRQ - 32;

    for (genvar k = 0; k < NLINE; k++) begin : g_tgt
        always_ff @(posedge clk) begin
            if (!rst_n)
                tgt[k] <= '0;
            else if (wr_en && int'(wr_id) == 32 + k)
                tgt[k] <= wr_mask;
        end
    end

    always_comb begin
        rd_mask = '0;
        if (int'(rd_id) >= 29 && int'(rd_id) < 32)
            rd_mask[req_core] = 1'b1;
        else if (int'(rd_id) >= 32 && int'(rd_id) < NIRQ)
            rd_mask = tgt[int'(rd_id) - 32];
    end
endmodule

// File: rtl/irq_distributor.sv
module irq_distributor import dist_pkg::*; #(
    parameter int NCORE = 2,
    parameter int NIRQ  = 64,
    localparam int CORE_W = (NCORE > 1) ? $clog2(NCORE) : 1,
    localparam int NLINE  = NIRQ - 32
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NLINE-1:0]        irq_line,
    input  logic                    wr_valid,
    input  logic [2:0]              wr_op,
    input  logic [ID_W-1:0]         wr_index,
    input  logic [7:0]              wr_data,
    input  logic [CORE_W-1:0]       req_core,
    input  logic                    sgi_valid,
    input  logic [31:0]             sgi_word,
    input  logic [ID_W-1:0]         tgt_rd_id,
    output logic [NCORE-1:0]        tgt_rd_data,
    output logic [NIRQ-1:0]         en_vec,
    output logic [NCORE*NIRQ-1:0]   pend_vec,
    output logic [NIRQ-1:0]         model_vec,
    output logic [NIRQ-1:0]         edge_vec,
    output logic                    acc_err
);
    localparam logic [NIRQ-1:0] LOW16 = NIRQ'(16'hFFFF);

    logic [NIRQ-1:0]             en_q, en_n, model_q, model_n, edge_q, edge_n;
    logic [NCORE-1:0][NIRQ-1:0]  pend_q, pend_n;
    logic                        err_q, err_n;
    logic [NLINE-1:0]            level, rise;
    logic [NLINE-1:0][NCORE-1:0] tgt;
    logic [NCORE-1:0]            sgi_mask, self_bit;
    logic [ID_W-1:0]             sgi_id;
    dist_op_e                    op;
    int                          base;
    logic                        in_range, known_op, tgt_wr;

    assign op = dist_op_e'(wr_op);

    dist_line_detect #(.NLINE(NLINE)) u_line (
        .clk(clk), .rst_n(rst_n), .line_in(irq_line), .level_q(level), .rise(rise)
    );

    dist_sgi_decode #(.NCORE(NCORE), .CORE_W(CORE_W)) u_sgi (
        .word(sgi_word), .req_core(req_core), .id(sgi_id), .mask(sgi_mask)
    );

    dist_target_regs #(.NCORE(NCORE), .NIRQ(NIRQ), .CORE_W(CORE_W)) u_tgt (
        .clk(clk), .rst_n(rst_n), .wr_en(tgt_wr), .wr_id(wr_index),
        .wr_mask(wr_data[NCORE-1:0]), .rd_id(tgt_rd_id), .req_core(req_core),
        .rd_mask(tgt_rd_data), .tgt(tgt)
    );

    // Access decode: first interrupt covered by the write
    always_comb begin
        unique case (op)
            OP_SET_EN, OP_CLR_EN, OP_SET_PEND, OP_CLR_PEND: base = int'(wr_index) * 8;
            OP_CONFIG:                                      base = int'(wr_index) * 4;
            default:                                        base = int'(wr_index);
        endcase
        self_bit           = '0;
        self_bit[req_core] = 1'b1;
    end

    assign in_range = base < NIRQ;
    assign known_op = (op != OP_RSV6) && (op != OP_RSV7);
    assign tgt_wr   = wr_valid && op == OP_TARGET && in_range;

    // Next-state merge: line events, then register write, then command
    always_comb begin
        en_n    = en_q;
        pend_n  = pend_q;
        model_n = model_q;
        edge_n  = edge_q;
        err_n   = 1'b0;

        for (int k = 0; k < NLINE; k++) begin
            if (rise[k] && (edge_q[32+k] || en_q[32+k]))
                for (int c = 0; c < NCORE; c++)
                    if (tgt[k][c]) pend_n[c][32+k] = 1'b1;
        end

        if (wr_valid && known_op && !in_range) err_n = 1'b1;

        if (wr_valid && in_range) begin
            unique case (op)
                OP_SET_EN: for (int b = 0; b < 8; b++) begin
                    if (base + b < 16 || wr_data[b]) begin
                        en_n[base+b] = 1'b1;
                        if (base + b >= 32 && !edge_q[base+b] && level[base+b-32])
                            for (int c = 0; c < NCORE; c++)
                                if (tgt[base+b-32][c]) pend_n[c][base+b] = 1'b1;
                    end
                end
                OP_CLR_EN: for (int b = 0; b < 8; b++) begin
                    if (base + b >= 16 && wr_data[b]) en_n[base+b] = 1'b0;
                end
                OP_SET_PEND: for (int b = 0; b < 8; b++) begin
                    if (wr_data[b])
                        for (int c = 0; c < NCORE; c++)
                            if (base + b < 32 ? self_bit[c] : tgt[base+b-32][c])
                                pend_n[c][base+b] = 1'b1;
                end
                OP_CLR_PEND: for (int b = 0; b < 8; b++) begin
                    if (wr_data[b])
                        for (int c = 0; c < NCORE; c++) pend_n[c][base+b] = 1'b0;
                end
                OP_CONFIG: for (int j = 0; j < 4; j++) begin
                    model_n[base+j] = wr_data[2*j];
                    edge_n[base+j]  = wr_data[2*j+1] || (base + j < 32);
                end
                default: ;
            endcase
        end

        if (sgi_valid) begin
            if (int'(sgi_id) < NIRQ) begin
                for (int c = 0; c < NCORE; c++)
                    if (sgi_mask[c]) pend_n[c][sgi_id] = 1'b1;
            end else begin
                err_n = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q    <= LOW16;
            edge_q  <= LOW16;
            model_q <= '0;
            pend_q  <= '0;
            err_q   <= 1'b0;
        end else begin
            en_q    <= en_n;
            edge_q  <= edge_n;
            model_q <= model_n;
            pend_q  <= pend_n;
            err_q   <= err_n;
        end
    end

    assign en_vec    = en_q;
    assign pend_vec  = pend_q;
    assign model_vec = model_q;
    assign edge_vec  = edge_q;
    assign acc_err   = err_q;
endmodule

// File: rtl/dist_chk.sv
module dist_chk #(
    parameter int CORE_W = 1,
    parameter int NCORE  = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              line0,
    input logic              wr_valid,
    input logic [2:0]        wr_op,
    input logic [9:0]        wr_index,
    input logic              wr_bit0,
    input logic [CORE_W-1:0] req_core,
    input logic              sgi_valid,
    input logic [9:0]        sgi_id,
    input logic [1:0]        sgi_filt,
    input logic [9:0]        tgt_rd_id,
    input logic [NCORE-1:0]  tgt_rd_data,
    input logic [15:0]       en_low,
    input logic [15:0]       edge_low,
    input logic              p0_i0,
    input logic              p1_i0,
    input logic              p0_i32,
    input logic              p1_i32,
    input logic              acc_err
);
    // R6
    low_always_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
        en_low == 16'hFFFF);

    // R7
    low_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        edge_low == 16'hFFFF);

    // R8
    clr_all_cores_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && wr_op == 3'd3 && wr_index == 10'd0 && wr_bit0 && !sgi_valid)
        |=> (!p0_i0 && !p1_i0));

    // R3
    fall_no_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!line0 && !wr_valid && !sgi_valid) |=> (!$rose(p0_i32) && !$rose(p1_i32)));

    // R10
    sgi_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sgi_valid && sgi_filt == 2'b11 && sgi_id == 10'd0 && !wr_valid)
        |=> (p0_i0 && p1_i0));

    // R11
    fixed_tgt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tgt_rd_id >= 10'd29 && tgt_rd_id <= 10'd31)
        |-> ($onehot(tgt_rd_data) && tgt_rd_data[req_core]));

    // R12
    err_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc_err |-> $past(wr_valid || sgi_valid));
endmodule

bind irq_distributor dist_chk #(.CORE_W(CORE_W), .NCORE(NCORE)) u_chk (
    .clk(clk), .rst_n(rst_n), .line0(irq_line[0]), .wr_valid(wr_valid),
    .wr_op(wr_op), .wr_index(wr_index), .wr_bit0(wr_data[0]), .req_core(req_core),
    .sgi_valid(sgi_valid), .sgi_id(sgi_word[9:0]), .sgi_filt(sgi_word[25:24]),
    .tgt_rd_id(tgt_rd_id), .tgt_rd_data(tgt_rd_data),
    .en_low(en_vec[15:0]), .edge_low(edge_vec[15:0]),
    .p0_i0(pend_vec[0]), .p1_i0(pend_vec[NIRQ]),
    .p0_i32(pend_vec[32]), .p1_i32(pend_vec[NIRQ+32]), .acc_err(acc_err)
);

// File: tb/test_irq_distributor.sv
`timescale 1ns/1ps
module test_irq_distributor;
    localparam int NCORE = 2;
    localparam int NIRQ  = 64;
    localparam int NVEC  = 14;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NIRQ-33:0]  irq_line = '0;
    logic              wr_valid = 1'b0;
    logic [2:0]        wr_op = '0;
    logic [9:0]        wr_index = '0;
    logic [7:0]        wr_data = '0;
    logic [0:0]        req_core = '0;
    logic              sgi_valid = 1'b0;
    logic [31:0]       sgi_word = '0;
    logic [9:0]        tgt_rd_id = '0;
    logic [NCORE-1:0]  tgt_rd_data;
    logic [NIRQ-1:0]   en_vec, model_vec, edge_vec;
    logic [NCORE*NIRQ-1:0] pend_vec;
    logic              acc_err;
    int checks = 0;
    int miscompares = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    irq_distributor #(.NCORE(NCORE), .NIRQ(NIRQ)) i_irq_distributor (
        .clk(clk), .rst_n(rst_n), .irq_line(irq_line), .wr_valid(wr_valid),
        .wr_op(wr_op), .wr_index(wr_index), .wr_data(wr_data), .req_core(req_core),
        .sgi_valid(sgi_valid), .sgi_word(sgi_word), .tgt_rd_id(tgt_rd_id),
        .tgt_rd_data(tgt_rd_data), .en_vec(en_vec), .pend_vec(pend_vec),
        .model_vec(model_vec), .edge_vec(edge_vec), .acc_err(acc_err)
    );

    // {tag, op, index, data, core, irq id, expected en, pend core0, pend core1}
    localparam logic [35:0] VEC [NVEC] = '{
        {4'd5,  3'd0, 10'd4,  8'h01, 1'b0, 7'd32, 3'b100}, // R5 enable, line low
        {4'd9,  3'd2, 10'd4,  8'h01, 1'b0, 7'd32, 3'b100}, // R9 empty target
        {4'd11, 3'd5, 10'd32, 8'h02, 1'b0, 7'd32, 3'b100}, // R11 target core1
        {4'd9,  3'd2, 10'd4,  8'h01, 1'b0, 7'd32, 3'b101}, // R9 shared
        {4'd8,  3'd3, 10'd4,  8'h01, 1'b0, 7'd32, 3'b100}, // R8
        {4'd9,  3'd2, 10'd2,  8'h04, 1'b1, 7'd18, 3'b001}, // R9 private core1
        {4'd9,  3'd2, 10'd2,  8'h04, 1'b0, 7'd18, 3'b011}, // R9 private core0
        {4'd8,  3'd3, 10'd2,  8'h04, 1'b1, 7'd18, 3'b000}, // R8 all cores
        {4'd6,  3'd1, 10'd0,  8'hFF, 1'b0, 7'd5,  3'b100}, // R6 cannot disable
        {4'd6,  3'd1, 10'd4,  8'h01, 1'b0, 7'd32, 3'b000}, // R6 contrast
        {4'd6,  3'd0, 10'd2,  8'h01, 1'b0, 7'd16, 3'b100}, // R6
        {4'd6,  3'd1, 10'd2,  8'h01, 1'b0, 7'd16, 3'b000}, // R6
        {4'd6,  3'd0, 10'd1,  8'h00, 1'b0, 7'd9,  3'b100}, // R6 forced ones
        {4'd12, 3'd6, 10'd4,  8'h01, 1'b0, 7'd32, 3'b000}  // R12 reserved op
    };

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic do_wr(input logic [2:0] op, input logic [9:0] idx,
                         input logic [7:0] data, input logic core);
        @(negedge clk);
        wr_valid = 1'b1; wr_op = op; wr_index = idx; wr_data = data; req_core = core;
        @(negedge clk);
        wr_valid = 1'b0;
    endtask

    task automatic do_sgi(input logic [31:0] word, input logic core);
        @(negedge clk);
        sgi_valid = 1'b1; sgi_word = word; req_core = core;
        @(negedge clk);
        sgi_valid = 1'b0;
    endtask

    function automatic logic [1:0] pends(input int id);
        return {pend_vec[NIRQ+id], pend_vec[id]};
    endfunction

    task automatic report;
        $display("== %0d vectors applied, %0d miscompares ==", checks, miscompares);
        $finish;
    endtask

    initial begin
        logic [63:0] en_before;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 en", en_vec, 64'h0000_0000_0000_FFFF);
        chk("R1 edge", edge_vec, 64'h0000_0000_0000_FFFF);
        chk("R1 model", model_vec, 64'h0);
        chk("R1 pend", pend_vec[63:0] | pend_vec[127:64], 64'h0);
        chk("R1 err", acc_err, 0);

        for (int v = 0; v < NVEC; v++) begin
            logic [35:0] e;
            int id;
            e = VEC[v];
            do_wr(e[31:29], e[28:19], e[18:11], e[10]);
            id = int'(e[9:3]);
            chk($sformatf("R%0d vec%0d en", e[35:32], v), en_vec[id], e[2]);
            chk($sformatf("R%0d vec%0d pend", e[35:32], v), pends(id), {e[0], e[1]});
        end
        chk("R12 reserved op no err", acc_err, 0);

        // R7 configuration fields
        do_wr(3'd4, 10'd8, 8'b0000_0110, 1'b0);
        chk("R7 irq32 edge", edge_vec[32], 1);
        chk("R7 irq32 model", model_vec[32], 0);
        chk("R7 irq33 fields", {model_vec[33], edge_vec[33]}, 2'b10);
        do_wr(3'd4, 10'd4, 8'h01, 1'b0);
        chk("R7 private edge forced", edge_vec[19:16], 4'hF);
        chk("R7 private model", model_vec[17:16], 2'b01);

        // R2 edge line, disabled, target core1
        @(negedge clk) irq_line[0] = 1'b1;
        @(negedge clk);
        chk("R2 edge rise pends target", pends(32), 2'b10);
        @(negedge clk) irq_line[0] = 1'b0;
        @(negedge clk);
        chk("R3 fall keeps pending", pends(32), 2'b10);
        do_wr(3'd3, 10'd4, 8'h01, 1'b0);

        // R3/R4/R5 level line 33
        do_wr(3'd5, 10'd33, 8'h03, 1'b0);
        @(negedge clk) irq_line[1] = 1'b1;
        @(negedge clk);
        chk("R3 level disabled no pend", pends(33), 2'b00);
        do_wr(3'd0, 10'd4, 8'h02, 1'b0);
        chk("R5 enable with line high pends", pends(33), 2'b11);
        do_wr(3'd3, 10'd4, 8'h02, 1'b1);
        repeat (3) @(negedge clk);
        chk("R4 held line no re-pend", pends(33), 2'b00);
        @(negedge clk) irq_line[1] = 1'b0;
        @(negedge clk);
        do_wr(3'd0, 10'd4, 8'h02, 1'b0);
        chk("R3 level cleared by fall", pends(33), 2'b00);
        @(negedge clk) irq_line[1] = 1'b1;
        @(negedge clk);
        chk("R2 enabled level rise pends", pends(33), 2'b11);

        // R10 software filters
        do_sgi(32'h0002_0028, 1'b0);
        chk("R10 filter0 list", pends(40), 2'b10);
        do_sgi(32'h0100_0029, 1'b0);
        chk("R10 filter1 self", pends(41), 2'b01);
        do_sgi(32'h0200_002A, 1'b0);
        chk("R10 filter2 others", pends(42), 2'b10);
        do_sgi(32'h0300_002B, 1'b1);
        chk("R10 filter3 all", pends(43), 2'b11);

        // R11 target read port
        @(negedge clk) begin tgt_rd_id = 10'd5; req_core = 1'b1; end
        #1 chk("R11 low id zero", tgt_rd_data, 2'b00);
        tgt_rd_id = 10'd30;
        #1 chk("R11 fixed core1", tgt_rd_data, 2'b10);
        req_core = 1'b0;
        #1 chk("R11 fixed core0", tgt_rd_data, 2'b01);
        tgt_rd_id = 10'd32;
        #1 chk("R11 stored mask", tgt_rd_data, 2'b10);
        do_wr(3'd5, 10'd20, 8'h03, 1'b0);
        tgt_rd_id = 10'd20;
        #1 chk("R11 private write ignored", tgt_rd_data, 2'b00);

        // R12 out of range
        en_before = en_vec;
        do_wr(3'd0, 10'd8, 8'hFF, 1'b0);
        chk("R12 err set-enable", acc_err, 1);
        chk("R12 no state change", en_vec, en_before);
        @(negedge clk);
        chk("R12 err one cycle", acc_err, 0);
        do_sgi(32'h0300_0064, 1'b0);
        chk("R12 err sgi", acc_err, 1);
        do_wr(3'd4, 10'd16, 8'hFF, 1'b0);
        chk("R12 err config", acc_err, 1);
        chk("R12 config unchanged", edge_vec[63:32], 32'h1);

        done = 1'b1;
        report();
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog: actual hung expected finish");
            report();
        end
    end
endmodule